// File: doc/BRIEF.md
# Bit-Plane Coding Pass Sequencer

This block walks one code block of sign/magnitude samples through the bit-plane coding passes of an embedded block coder. It first reads every sample once to find the highest magnitude bit that is set anywhere in the block. It then codes from that plane down to plane zero. Each coding decision becomes a (context, bit) pair. The pairs are written into a small queue. An output controller hands them one at a time to a downstream serial arithmetic coder over a ready/valid handshake.

Samples sit in an external synchronous memory with one cycle of read latency, stored in raster order. The block reads them stripe by stripe, where a stripe is four rows tall. Within a stripe it scans column by column, and within each column it visits the four rows from top to bottom. Per-sample significance and coded-this-plane flags are kept in local registers.

After the final cleanup pass, the block waits for the queue to empty. It then requests a flush from the coder, follows it with a one-cycle coder reset, and reports completion.

Top module: `bpc_pass_seq`

## Requirements
- R1: Out of reset `cd_valid`, `cd_flush`, `cd_reset`, `done` and `mem_rd_en` are all low.
- R2: After `start`, one read sweep finds the highest set magnitude bit T over the whole block. Plane T receives only a cleanup pass.
- R3: Every plane below T receives three passes in this order: significance propagation, magnitude refinement, cleanup. The block therefore issues N·(1 + 1 + 3T) reads for an N-sample block.
- R4: Each pass (and the initial sweep) reads samples in stripe order, then column, then row 0..3 within the stripe. Row y, column x is at address y·COLS + x.
- R5: Significance propagation codes a sample only if it is not yet significant and at least one of its two causal neighbours (the sample directly above and the sample directly to the left) is significant. The context is the count of such neighbours (1 or 2).
- R6: Magnitude refinement codes each sample that was significant before the current plane, with context 3.
- R7: Cleanup codes each sample not yet significant and not coded earlier in the plane, with context 4 plus its significant-neighbour count (0..2).
- R8: When a significance or cleanup decision bit is 1, the sample becomes significant. The next pair is then its sign: context 7, bit equal to memory bit MAG_BITS (1 = negative).
- R9: One pair moves per cycle with `cd_valid` and `cd_ready` both high. While `cd_ready` is low the offered pair is held unchanged. The queue never overflows, and no pair is lost or reordered.
- R10: Once every pair has been accepted, `cd_flush` is raised and held, with `cd_valid` low, until `cd_ready`. The next cycle `cd_reset` pulses for exactly one cycle, and `done` then rises.
- R11: A block whose magnitudes are all zero produces no pairs, only the flush and reset.
- R12: `done` stays high until the next `start`, which begins a fresh block with cleared flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin coding the block held in memory |
| mem_rd_en | output | 1 | Sample read request |
| mem_rd_addr | output | AW | Raster address of the sample |
| mem_rd_data | input | MAG_BITS+1 | Sample read one cycle after the request: sign in the top bit, magnitude below |
| cd_valid | output | 1 | A pair is offered to the coder |
| cd_ready | input | 1 | Coder accepts a pair or the flush |
| cd_ctx | output | CW | Context of the offered pair |
| cd_bit | output | 1 | Decision bit of the offered pair |
| cd_flush | output | 1 | Flush request to the coder |
| cd_reset | output | 1 | One-cycle coder reset after the flush |
| done | output | 1 | Block finished |

## Verification
The flags evolve in a fixed sequence. A wrong significance or coded flag therefore changes a context or removes a pair. This shows up at the first affected pair on `cd_ctx`/`cd_bit`, normally within the same pass, and always before the flush. A wrong plane or pass counter changes the number and order of memory reads, which a comparison of every `mem_rd_addr` against the scan order catches in the first wrong cycle. Queue pointer faults show as duplicated, missing or altered pairs under random backpressure. Sequencing faults at the end show as a flush raised while pairs remain, or as a missing or stretched reset.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_SCAN_RD, ST_SCAN_EV, ST_RD, ST_EV,
        ST_SIGN, ST_DRAIN, ST_FLUSH, ST_CRST, ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        PASS_SP = 2'd0,
        PASS_MR = 2'd1,
        PASS_CU = 2'd2
    } pass_e;
endpackage

// File: rtl/bpc_ctx_map.sv
module bpc_ctx_map
    import bpc_pkg::*;
#(
    parameter int CW       = 3,
    parameter int SP_BASE  = 0,
    parameter int MR_CTX   = 3,
    parameter int CU_BASE  = 4,
    parameter int SIGN_CTX = 7
) (
    input  pass_e         pass,
    input  logic [1:0]    nbr,
    input  logic          is_sign,
    output logic [CW-1:0] ctx
);
    always_comb begin
        if (is_sign)              ctx = CW'(SIGN_CTX);
        else if (pass == PASS_MR) ctx = CW'(MR_CTX);
        else if (pass == PASS_SP) ctx = CW'(SP_BASE) + CW'(nbr);
        else                      ctx = CW'(CU_BASE) + CW'(nbr);
    end
endmodule

// File: rtl/bpc_pair_fifo.sv
module bpc_pair_fifo #(
    parameter int W     = 4,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTRW-1:0] wp;
        logic [PTRW-1:0] rp;
        logic [CNTW-1:0] cnt;
    } fifo_t;

    fifo_t q, d;
    logic [W-1:0] store [DEPTH];

    always_comb begin
        d = q;
        if (push) d.wp = (q.wp == PTRW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        if (pop)  d.rp = (q.rp == PTRW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        case ({push, pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push) store[q.wp] <= din;
    end

    assign dout  = store[q.rp];
    assign full  = (q.cnt == CNTW'(DEPTH));
    assign empty = (q.cnt == '0);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/bpc_pass_seq.sv
module bpc_pass_seq
    import bpc_pkg::*;
#(
    parameter int COLS     = 4,
    parameter int ROWS     = 8,
    parameter int MAG_BITS = 4,
    parameter int QDEPTH   = 4,
    parameter int CW       = 3,
    localparam int N       = ROWS * COLS,
    localparam int AW      = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic [MAG_BITS:0] mem_rd_data,
    output logic              cd_valid,
    input  logic              cd_ready,
    output logic [CW-1:0]     cd_ctx,
    output logic              cd_bit,
    output logic              cd_flush,
    output logic              cd_reset,
    output logic              done
);
    localparam int STRIPES = ROWS / 4;
    localparam int SBW     = (STRIPES > 1) ? $clog2(STRIPES) : 1;
    localparam int CBW     = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int PW      = (MAG_BITS > 1) ? $clog2(MAG_BITS) : 1;

    typedef struct packed {
        seq_state_e          st;
        pass_e               pass;
        logic [PW-1:0]       plane;
        logic [SBW-1:0]      s;
        logic [CBW-1:0]      c;
        logic [1:0]          r;
        logic [N-1:0]        sig;
        logic [N-1:0]        coded;
        logic [MAG_BITS-1:0] orv;
    } seq_t;

    seq_t q, d;

    logic [AW-1:0]       cur_k;
    logic [1:0]          nbr;
    logic [MAG_BITS-1:0] mag;
    logic                bitv, last, step, want;
    logic                q_push, q_pop, q_full, q_empty, is_sign;
    logic [CW-1:0]       ctx;
    logic [CW:0]         q_din, q_dout;

    function automatic logic [PW-1:0] top_bit(input logic [MAG_BITS-1:0] v);
        logic [PW-1:0] res = '0;
        for (int i = 0; i < MAG_BITS; i++) if (v[i]) res = PW'(i);
        return res;
    endfunction

    assign is_sign = (q.st == ST_SIGN);

    bpc_ctx_map #(.CW(CW)) u_ctx (
        .pass(q.pass), .nbr(nbr), .is_sign(is_sign), .ctx(ctx)
    );

    bpc_pair_fifo #(.W(CW + 1), .DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(q_push), .din(q_din),
        .pop(q_pop), .dout(q_dout), .full(q_full), .empty(q_empty)
    );

    assign cd_valid = !q_empty;
    assign q_pop    = cd_valid && cd_ready;
    assign cd_ctx   = q_dout[CW:1];
    assign cd_bit   = q_dout[0];

    always_comb begin
        cur_k = AW'((int'(q.s) * 4 + int'(q.r)) * COLS + int'(q.c));
        nbr   = {1'b0, ((q.s != '0) || (q.r != '0)) && q.sig[cur_k - AW'(COLS)]}
              + {1'b0, (q.c != '0) && q.sig[cur_k - AW'(1)]};
        mag   = mem_rd_data[MAG_BITS-1:0];
        bitv  = mag[q.plane];
        last  = (q.s == SBW'(STRIPES - 1)) && (q.c == CBW'(COLS - 1)) && (q.r == 2'd3);
        case (q.pass)
            PASS_SP: want = !q.sig[cur_k] && (nbr != 2'd0);
            PASS_MR: want = q.sig[cur_k] && !q.coded[cur_k];
            default: want = !q.sig[cur_k] && !q.coded[cur_k];
        endcase
    end

    always_comb begin
        d         = q;
        step      = 1'b0;
        q_push    = 1'b0;
        q_din     = {ctx, bitv};
        mem_rd_en = (q.st == ST_SCAN_RD) || (q.st == ST_RD);
        mem_rd_addr = cur_k;
        cd_flush  = (q.st == ST_FLUSH);
        cd_reset  = (q.st == ST_CRST);
        done      = (q.st == ST_DONE);

        case (q.st)
            ST_IDLE, ST_DONE: if (start) begin
                d.st    = ST_SCAN_RD;
                d.sig   = '0;
                d.coded = '0;
                d.orv   = '0;
                d.s = '0; d.c = '0; d.r = '0;
            end
            ST_SCAN_RD: d.st = ST_SCAN_EV;
            ST_SCAN_EV: begin
                d.orv = q.orv | mag;
                if (last) begin
                    d.s = '0; d.c = '0; d.r = '0;
                    if ((q.orv | mag) == '0) begin
                        d.st = ST_DRAIN;
                    end else begin
                        d.plane = top_bit(q.orv | mag);
                        d.pass  = PASS_CU;
                        d.st    = ST_RD;
                    end
                end else begin
                    d.st = ST_SCAN_RD;
                    step = 1'b1;
                end
            end
            ST_RD: d.st = ST_EV;
            ST_EV: begin
                if (!want) begin
                    step = 1'b1;
                end else if (!q_full) begin
                    q_push         = 1'b1;
                    d.coded[cur_k] = 1'b1;
                    if (q.pass != PASS_MR && bitv) begin
                        d.sig[cur_k] = 1'b1;
                        d.st         = ST_SIGN;
                    end else begin
                        step = 1'b1;
                    end
                end
            end
            ST_SIGN: if (!q_full) begin
                q_push = 1'b1;
                q_din  = {ctx, mem_rd_data[MAG_BITS]};
                step   = 1'b1;
            end
            ST_DRAIN: if (q_empty) d.st = ST_FLUSH;
            ST_FLUSH: if (cd_ready) d.st = ST_CRST;
            ST_CRST:  d.st = ST_DONE;
            default:  d.st = ST_IDLE;
        endcase

        if (step && q.st != ST_SCAN_EV) begin
            d.st = ST_RD;
            if (last) begin
                d.s = '0; d.c = '0; d.r = '0;
                case (q.pass)
                    PASS_SP: d.pass = PASS_MR;
                    PASS_MR: d.pass = PASS_CU;
                    default: begin
                        if (q.plane == '0) begin
                            d.st = ST_DRAIN;
                        end else begin
                            d.plane = q.plane - 1'b1;
                            d.pass  = PASS_SP;
                            d.coded = '0;
                        end
                    end
                endcase
            end
        end
        if (step && !last) begin
            d.r = q.r + 2'd1;
            if (q.r == 2'd3) begin
                if (q.c == CBW'(COLS - 1)) begin
                    d.c = '0;
                    d.s = q.s + 1'b1;
                end else begin
                    d.c = q.c + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.pass <= PASS_CU;
        end else begin
            q <= d;
        end
    end

    p_flush_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cd_flush |-> !cd_valid);
    p_reset_after_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_flush && cd_ready) |=> cd_reset);
    p_reset_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cd_reset |=> (!cd_reset && done));
    p_hold_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_valid && !cd_ready) |=> (cd_valid && $stable(cd_ctx) && $stable(cd_bit)));
    p_sign_follows_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_sign) |-> $past(q_push) && $past(q_din[0]));
    p_no_read_when_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_rd_en && !cd_valid);
endmodule

// File: tb/tb_bpc_pass_seq.sv
module tb_bpc_pass_seq;
    localparam int COLS = 4, ROWS = 8, MAG = 4, N = ROWS * COLS, AW = $clog2(N);
    localparam int CW = 3;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cd_ready = 1'b0;
    logic mem_rd_en, cd_valid, cd_bit, cd_flush, cd_reset, done;
    logic [AW-1:0] mem_rd_addr;
    logic [MAG:0]  mem_rd_data;
    logic [CW-1:0] cd_ctx;

    always #2 clk = ~clk;

    bpc_pass_seq #(.COLS(COLS), .ROWS(ROWS), .MAG_BITS(MAG), .QDEPTH(4), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .cd_valid(cd_valid),
        .cd_ready(cd_ready), .cd_ctx(cd_ctx), .cd_bit(cd_bit), .cd_flush(cd_flush),
        .cd_reset(cd_reset), .done(done)
    );

    logic [MAG:0] bmem [N];
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= bmem[mem_rd_addr];

    int checks = 0, fails = 0;
    logic [CW:0] exp_pair [512];
    int exp_n, exp_reads, got, rd_cnt, rd_bad, rmode;
    logic mon_en = 1'b0, hold_pend, flush_seen, fl_pend, rst_pend;
    logic [CW:0] hold_val;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic add_pair(input int ctx, input logic b);
        exp_pair[exp_n] = {CW'(ctx), b};
        exp_n++;
    endtask

    function automatic int scan_addr(input int j);
        int kk = j % N;
        int s = kk / (4 * COLS);
        int rem = kk % (4 * COLS);
        return (s * 4 + rem % 4) * COLS + rem / 4;
    endfunction

    // Golden model written from R2..R8
    task automatic build_expected();
        logic [N-1:0] sg, cd;
        int orv = 0, top = 0;
        exp_n = 0;
        exp_reads = N;
        for (int k = 0; k < N; k++) orv |= int'(bmem[k][MAG-1:0]);
        if (orv == 0) return;
        for (int b = 0; b < MAG; b++) if (orv[b]) top = b;
        sg = '0;
        for (int p = top; p >= 0; p--) begin
            cd = '0;
            for (int ps = (p == top) ? 2 : 0; ps <= 2; ps++) begin
                exp_reads += N;
                for (int j = 0; j < N; j++) begin
                    int k = scan_addr(j);
                    int nb = 0;
                    logic bv = bmem[k][p];
                    if (k >= COLS && sg[k-COLS]) nb++;
                    if ((k % COLS) != 0 && sg[k-1]) nb++;
                    if (ps == 0 && !sg[k] && nb > 0) begin
                        add_pair(nb, bv); cd[k] = 1'b1;
                        if (bv) begin sg[k] = 1'b1; add_pair(7, bmem[k][MAG]); end
                    end else if (ps == 1 && sg[k] && !cd[k]) begin
                        add_pair(3, bv); cd[k] = 1'b1;
                    end else if (ps == 2 && !sg[k] && !cd[k]) begin
                        add_pair(4 + nb, bv); cd[k] = 1'b1;
                        if (bv) begin sg[k] = 1'b1; add_pair(7, bmem[k][MAG]); end
                    end
                end
            end
        end
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            case (rmode)
                0:       cd_ready = 1'b1;
                1:       cd_ready = ($urandom % 2) == 0;
                default: cd_ready = ($urandom % 4) == 0;
            endcase
            if (hold_pend)
                check(cd_valid && {cd_ctx, cd_bit} == hold_val, "R9 hold",
                      int'({cd_ctx, cd_bit}), int'(hold_val));
            hold_pend = cd_valid && !cd_ready;
            hold_val  = {cd_ctx, cd_bit};
            if (cd_valid && cd_ready) begin
                check(got < exp_n && {cd_ctx, cd_bit} == exp_pair[got],
                      "R5/R6/R7/R8 pair", int'({cd_ctx, cd_bit}), int'(exp_pair[got]));
                got++;
            end
            if (mem_rd_en) begin
                if (int'(mem_rd_addr) != scan_addr(rd_cnt)) rd_bad++;
                rd_cnt++;
            end
            if (rst_pend) begin
                check(!cd_reset && done, "R10 reset one cycle then done",
                      int'({cd_reset, done}), 1);
                rst_pend = 1'b0;
            end
            if (fl_pend) begin
                check(cd_reset, "R10 reset after flush", int'(cd_reset), 1);
                fl_pend = 1'b0; rst_pend = 1'b1;
            end
            if (cd_flush && cd_ready && !flush_seen) begin
                flush_seen = 1'b1;
                check(got == exp_n && !cd_valid, "R10/R11 all pairs before flush", got, exp_n);
                fl_pend = 1'b1;
            end
        end
    end

    bit wd_hit = 1'b0;

    task automatic run_block(input int mode);
        int cyc = 0;
        build_expected();
        rmode = mode; got = 0; rd_cnt = 0; rd_bad = 0;
        hold_pend = 0; flush_seen = 0; fl_pend = 0; rst_pend = 0;
        @(negedge clk);
        start = 1'b1; mon_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
        if (!done) begin
            check(1'b0, "watchdog", cyc, 20000);
            wd_hit = 1'b1;
        end
        repeat (3) @(negedge clk);
        mon_en = 1'b0;
        check(flush_seen, "R10 flush seen", int'(flush_seen), 1);
        check(got == exp_n, "R9 pair count", got, exp_n);
        check(rd_bad == 0, "R4 scan order", rd_bad, 0);
        check(rd_cnt == exp_reads, "R2/R3 pass count by reads", rd_cnt, exp_reads);
        check(done, "R12 done held", int'(done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!cd_valid && !cd_flush && !cd_reset && !done && !mem_rd_en,
              "R1 reset state", int'({cd_valid, cd_flush, cd_reset, done, mem_rd_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !mem_rd_en, "R1 idle after reset", int'({done, mem_rd_en}), 0);

        // R11: all-zero block
        for (int k = 0; k < N; k++) bmem[k] = '0;
        run_block(1);
        check(exp_n == 0 && got == 0, "R11 no pairs", got, 0);

        // R2: one sample of magnitude 1, top plane only cleanup
        if (!wd_hit) begin
            for (int k = 0; k < N; k++) bmem[k] = '0;
            bmem[9] = 5'b1_0001;
            run_block(0);
        end
        // R2/R3: single larger sample, neighbours
        if (!wd_hit) begin
            for (int k = 0; k < N; k++) bmem[k] = '0;
            bmem[5] = 5'b0_0110; bmem[6] = 5'b1_0011; bmem[13] = 5'b0_0001;
            run_block(2);
        end
        // checkerboard full range, negative signs
        if (!wd_hit) begin
            for (int k = 0; k < N; k++) bmem[k] = ((k / COLS + k) % 2 == 0) ? 5'b1_1111 : 5'b0_0101;
            run_block(1);
        end
        // R12: several random blocks back to back, various backpressure
        for (int t = 0; t < 6 && !wd_hit; t++) begin
            for (int k = 0; k < N; k++) bmem[k] = 5'($urandom % 32);
            repeat (5) @(negedge clk);
            check(done, "R12 done persists until start", int'(done), 1);
            run_block(t % 3);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule